// File: doc/BRIEF.md
# Converter Serial Output Sequencer

This block is a device-side, clock-accurate model of the serial port of a sampling analog-to-digital converter. A host controller under test drives an active-low chip-select and a serial clock. The block counts the falling edges of that serial clock and drives a single serial data line. The line carries a leading zero bit, then a two's-complement result sent most significant bit first. If chip-select stays low, the same result follows again least significant bit first. The sample value comes from a parallel test input, so the host's receive path can be exercised with chosen codes.

The block does not make the tri-state pad itself. It provides the data bit and a separate drive-enable, and a board-level wrapper builds the pad from them. While the enable is low the line is considered high-impedance. Two activity flags model power state. The converter-active flag falls once the last result bit has been produced. The interface-active flag stays high until chip-select is released.

Chip-select and the serial clock are sampled on a faster system clock. Each output update appears one system clock after the sampled edge that causes it.

Top module: `adc_serial_seq`

## Requirements
- R1: A frame starts only when chip-select is seen going from high to low. Serial clock edges while chip-select is high, or after a frame has finished, leave the data enable low.
- R2: Counting falling serial clock edges from the chip-select fall, the data enable stays low through the first edge. On the 2nd edge it rises and the data line carries a 0 (the leading zero bit).
- R3: On falling edges 3 to 14 the data line carries result bits 11 down to 0, one bit per edge, most significant bit first.
- R4: While chip-select stays low, edges 15 to 25 carry result bits 1 up to 11, least significant bit first, without resending bit 0. From edge 26 onward the enable is low.
- R5: If chip-select is raised after edge 14 or edge 15, no further result bits are driven.
- R6: A rising chip-select drops the data enable one system clock later at any point of a frame, and ends that frame.
- R7: The sample input is captured on edge 2. Later changes to it do not alter the bits sent in that frame.
- R8: The converter-active flag is high from the chip-select fall until edge 14, and low from edge 14 on. The interface-active flag is high from the chip-select fall until chip-select rises. Neither flag is high outside a frame.
- R9: The result is sent bit-exact for the two's-complement extremes: 0x7FF (positive full scale), 0x000, 0xFFF (one step below zero) and 0x800 (negative full scale).
- R10: Whenever the data enable is low, the data line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip-select from the host |
| serClk | input | 1 | Serial clock from the host |
| sampleIn | input | DATA_W | Parallel test value to be converted |
| serData | output | 1 | Serial data bit |
| serDataEn | output | 1 | High when the serial line is driven, low for high-impedance |
| convActive | output | 1 | Converter section active flag |
| ifActive | output | 1 | Interface section active flag |

## Verification
Two corners are the hardest to reach from the ports. The first is the boundary between the forward word and the reversed echo: the host must hold chip-select low past edge 14 and then release it exactly after edge 14 or edge 15. The second is a change of the sample input in the middle of a frame. The stimulus draws the release point at random over the whole frame and beyond it, and it also forces releases after edges 14 and 15 directly. In random frames the sample input is replaced with a fresh random value right after edge 2, so every later bit shows whether the captured copy was used.

// File: rtl/adc_serial_seq_pkg.sv
package adc_serial_seq_pkg;

  // widest bit select supported (words up to 64 bits)
  localparam int SEL_W = 6;

  typedef struct packed {
    logic             clear;    // chip-select edge: drop the output
    logic             step;     // counted serial clock fall
    logic             capture;  // latch the sample input
    logic             drive;    // line driven after this step
    logic             isNull;   // leading zero bit
    logic [SEL_W-1:0] bitSel;   // result bit to present
  } seq_strobe_t;

endpackage

// File: rtl/adc_serial_seq_ctrl.sv
module adc_serial_seq_ctrl
  import adc_serial_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        serClk,
  output seq_strobe_t strb,
  output logic        convActive,
  output logic        ifActive
);

  localparam int CNT_W = $clog2(2 * DATA_W + 3);
  localparam logic [CNT_W-1:0] NULL_EDGE = CNT_W'(2);
  localparam logic [CNT_W-1:0] LSB_EDGE  = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] DONE_EDGE = CNT_W'(2 * DATA_W + 2);

  logic             prevCs;
  logic             prevClk;
  logic             csFall;
  logic             csRise;
  logic             clkFall;
  logic             inFrame;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             stepNow;
  logic             convReg;

  assign csFall  = prevCs & ~csN;
  assign csRise  = ~prevCs & csN;
  assign clkFall = prevClk & ~serClk;
  assign nextCnt = edgeCnt + CNT_W'(1);
  assign stepNow = inFrame & ~csFall & ~csRise & clkFall & (edgeCnt != DONE_EDGE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs  <= 1'b0;
      prevClk <= 1'b0;
    end else begin
      prevCs  <= csN;
      prevClk <= serClk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      edgeCnt <= '0;
      convReg <= 1'b0;
    end else if (csFall) begin
      inFrame <= 1'b1;
      edgeCnt <= '0;
      convReg <= 1'b1;
    end else if (csRise) begin
      inFrame <= 1'b0;
      edgeCnt <= '0;
      convReg <= 1'b0;
    end else if (stepNow) begin
      edgeCnt <= nextCnt;
      if (nextCnt == LSB_EDGE) begin
        convReg <= 1'b0;
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.clear   = csFall | csRise;
    strb.step    = stepNow;
    strb.capture = stepNow & (nextCnt == NULL_EDGE);
    strb.isNull  = (nextCnt == NULL_EDGE);
    strb.drive   = (nextCnt >= NULL_EDGE) && (nextCnt < DONE_EDGE);
    if (nextCnt <= LSB_EDGE) begin
      strb.bitSel = SEL_W'(LSB_EDGE - nextCnt);
    end else begin
      strb.bitSel = SEL_W'(nextCnt - LSB_EDGE);
    end
  end

  assign convActive = convReg;
  assign ifActive   = inFrame;

  // R8
  conv_within_if_chk: assert property (@(posedge clk) disable iff (!rstN)
    convActive |-> ifActive);

  // R6
  rise_ends_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !$past(csN)) |=> !ifActive);

endmodule

// File: rtl/adc_serial_seq_dp.sv
module adc_serial_seq_dp
  import adc_serial_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  seq_strobe_t       strb,
  output logic              serData,
  output logic              serDataEn
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] heldWord;
  logic [IDX_W-1:0]  pickIdx;
  logic              pickBit;

  assign pickIdx = IDX_W'(strb.bitSel);
  assign pickBit = heldWord[pickIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
    end else if (strb.capture) begin
      heldWord <= sampleIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serData   <= 1'b0;
      serDataEn <= 1'b0;
    end else if (strb.clear) begin
      serData   <= 1'b0;
      serDataEn <= 1'b0;
    end else if (strb.step) begin
      serDataEn <= strb.drive;
      serData   <= strb.drive & ~strb.isNull & pickBit;
    end
  end

  // R10
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !serDataEn |-> !serData);

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_serial_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              serClk,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              serData,
  output logic              serDataEn,
  output logic              convActive,
  output logic              ifActive
);

  seq_strobe_t strb;

  adc_serial_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .serClk     (serClk),
    .strb       (strb),
    .convActive (convActive),
    .ifActive   (ifActive)
  );

  adc_serial_seq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .strb      (strb),
    .serData   (serData),
    .serDataEn (serDataEn)
  );

  // R6
  cs_rise_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> !serDataEn);

  // R1
  cs_high_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !serDataEn);

  // R2
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    serDataEn |-> ifActive);

endmodule

// File: tb/adc_serial_seq_tb.sv
module adc_serial_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         csN = 1'b1;
  logic         serClk = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic         serData;
  logic         serDataEn;
  logic         convActive;
  logic         ifActive;

  int  nChecks = 0;
  int  nErr    = 0;
  bit  allDone = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_serial_seq #(.DATA_W(W)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .serClk     (serClk),
    .sampleIn   (sampleIn),
    .serData    (serData),
    .serDataEn  (serDataEn),
    .convActive (convActive),
    .ifActive   (ifActive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expEn(input int k);
    return (k >= 2) && (k <= 2 * W + 1);
  endfunction

  function automatic logic expBit(input logic [W-1:0] w, input int k);
    if (k == 2) return 1'b0;
    if (k <= W + 2) return w[W + 2 - k];
    return w[k - W - 2];
  endfunction

  task automatic pulse();
    @(negedge clk) serClk = 1'b1;
    @(negedge clk) serClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic runFrame(input logic [W-1:0] word, input int stopAt,
                          input bit scramble, input string wtag);
    sampleIn = word;
    @(negedge clk) csN = 1'b0;
    @(negedge clk);
    chk("R2 enable low at frame start", serDataEn, 1'b0);
    chk("R8 conv flag at start", convActive, 1'b1);
    chk("R8 if flag at start", ifActive, 1'b1);
    for (int k = 1; k <= stopAt; k++) begin
      pulse();
      if (k == 2 && scramble) sampleIn = W'($urandom);
      chk((k <= W + 2) ? "R2/R3 enable" : "R4 enable", serDataEn, expEn(k));
      if (expEn(k)) begin
        if (k == 2) chk("R2 leading zero", serData, 1'b0);
        else if (k <= W + 2) chk(scramble ? "R7 forward bit" : {wtag, " R3 forward bit"},
                                 serData, expBit(word, k));
        else chk(scramble ? "R7 echo bit" : {wtag, " R4 echo bit"}, serData, expBit(word, k));
      end else begin
        chk("R10 idle line low", serData, 1'b0);
      end
      chk("R8 conv flag", convActive, k < W + 2);
      chk("R8 if flag", ifActive, 1'b1);
    end
    @(negedge clk) csN = 1'b1;
    @(negedge clk);
    chk((stopAt == W + 2 || stopAt == W + 3) ? "R5 no echo after release" : "R6 release",
        serDataEn, 1'b0);
    chk("R8 if flag after release", ifActive, 1'b0);
    chk("R8 conv flag after release", convActive, 1'b0);
    for (int j = 0; j < 2; j++) begin
      pulse();
      chk("R1 clock with cs high", serDataEn, 1'b0);
      chk("R10 line low with cs high", serData, 1'b0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!allDone) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R10 reset enable", serDataEn, 1'b0);
    chk("R8 reset conv flag", convActive, 1'b0);
    chk("R8 reset if flag", ifActive, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: clocking while chip-select stays high
    for (int j = 0; j < 3; j++) begin
      pulse();
      chk("R1 idle clocking", serDataEn, 1'b0);
    end
    // R9: extreme codes, full frames plus trailing edges
    runFrame(12'h7FF, 2 * W + 4, 1'b0, "R9 7FF");
    runFrame(12'h000, 2 * W + 4, 1'b0, "R9 000");
    runFrame(12'hFFF, 2 * W + 4, 1'b0, "R9 FFF");
    runFrame(12'h800, 2 * W + 4, 1'b0, "R9 800");
    // R5: release right after edges 14 and 15
    runFrame(12'hA5C, W + 2, 1'b0, "R5");
    runFrame(12'h3C1, W + 3, 1'b0, "R5");
    // R6: short cycles
    runFrame(12'h123, 1, 1'b0, "R6");
    runFrame(12'h9E7, 6, 1'b0, "R6");
    // random frames with the sample scrambled after capture (R7)
    for (int t = 0; t < 40; t++) begin
      runFrame(W'($urandom), int'($urandom % (2 * W + 6)), ($urandom % 2) == 1, "rnd");
    end
    allDone = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule